// File: doc/BRIEF.md
# Character-Clock Raster Timing Generator

This block produces the raster timing for a display head from a pixel clock. Software programs twelve timing fields and one control field through a plain write port. Horizontal fields are counted in character clocks of eight pixels and vertical fields in scan lines. Each field is stored with a fixed offset from the value it stands for. From these fields the block drives horizontal and vertical sync, the two blanking signals and a display enable, and it reports the scan line it is on as an 11-bit number.

The blank and sync pulses are set/clear flags. Each flag is set when the counter reaches the programmed start value. It is cleared when only the low bits of the counter match the programmed end value. An end value below the start value therefore makes the pulse run past the wrap of the counter. The timing fields pass through a shadow bank that is copied into the working set at the end of each frame, so no frame ever runs on a mix of old and new values. The control field acts at once: it holds sync polarity, a disable for each sync and a screen-off bit for power saving.

Top module: `crtc_timing`

## Requirements
- R1: While rst_n is low and on leaving reset, every timing field and the control field read as zero. hsync, vsync, hblank and vblank are low, raster_line is 0 and disp_en is high, because character 0 of line 0 lies inside a zero display end.
- R2: The character counter advances once every 8 pixel clocks. After character HTOTAL+4 it returns to 0, so a line lasts (HTOTAL+5)*8 clocks. HTOTAL is written at address 0.
- R3: The line counter advances when the character counter wraps. After line VTOTAL+1 it returns to 0, so a frame has VTOTAL+2 lines. raster_line shows the low 11 bits of the line counter. VTOTAL is written at address 6.
- R4: disp_en is high exactly when the character count is at most HDEND (address 1) and the line count is at most VDEND (address 7).
- R5: hblank rises on character HBSTART+1 (HBSTART at address 2). It stays high through the first later character whose low 6 bits equal HBEND (address 3, 6 bits) and falls on the character after it.
- R6: hsync goes active on character HSSTART (address 4). It goes inactive on the first later character whose low 5 bits equal HSEND (address 5, 5 bits). An HSEND below HSSTART carries the pulse across the line wrap.
- R7: vblank rises on line VBSTART+1 (address 8). It stays high through the first later line whose low 8 bits equal VBEND (address 9, 8 bits) and falls on the line after it.
- R8: vsync goes active on line VSSTART (address 10). It goes inactive on the first later line whose low 4 bits equal VSEND (address 11, 4 bits). A VSEND below VSSTART carries the pulse across the frame wrap.
- R9: Control bit 0 (horizontal) and bit 1 (vertical) at address 12 set the sync polarity: 0 makes the active level high, 1 makes it low.
- R10: Control bit 2 holds hsync at its inactive level and control bit 3 does the same for vsync. The blanking outputs and the counters are not affected.
- R11: Control bit 4 holds disp_en low. The counters, raster_line, the blanks and the syncs run on unchanged.
- R12: A write to a timing field (addresses 0 to 11) first acts on the frame that starts after the next frame wrap. A write to the control field acts on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address, 0 to 12 |
| wr_data | input | 11 | Register write data, low bits used per field |
| hsync | output | 1 | Horizontal sync, polarity per control bit 0 |
| vsync | output | 1 | Vertical sync, polarity per control bit 1 |
| hblank | output | 1 | Horizontal blanking, active high |
| vblank | output | 1 | Vertical blanking, active high |
| disp_en | output | 1 | Display enable, active high |
| raster_line | output | 11 | Current scan line number |

## Verification
On every cycle the assertions check the following:
- the character tick spacing;
- counter advance and return to zero at the programmed total;
- blank and sync flags changing only on a counter step;
- the working timing set staying frozen except at the frame wrap, where it takes the shadow contents;
- raster_line moving only at a line wrap.

Other behaviours only the bench's scenarios can show, because the pulse positions depend on the programmed values:
- where each pulse starts and ends;
- pulses that wrap through truncated end compares;
- polarity and disable levels;
- screen-off leaving the timing running;
- the one-frame delay of a timing write compared with a control write.

// File: rtl/crtc_pkg.sv
package crtc_pkg;

  // register addresses of the write port
  localparam logic [3:0] ADR_HTOTAL  = 4'd0;
  localparam logic [3:0] ADR_HDEND   = 4'd1;
  localparam logic [3:0] ADR_HBSTART = 4'd2;
  localparam logic [3:0] ADR_HBEND   = 4'd3;
  localparam logic [3:0] ADR_HSSTART = 4'd4;
  localparam logic [3:0] ADR_HSEND   = 4'd5;
  localparam logic [3:0] ADR_VTOTAL  = 4'd6;
  localparam logic [3:0] ADR_VDEND   = 4'd7;
  localparam logic [3:0] ADR_VBSTART = 4'd8;
  localparam logic [3:0] ADR_VBEND   = 4'd9;
  localparam logic [3:0] ADR_VSSTART = 4'd10;
  localparam logic [3:0] ADR_VSEND   = 4'd11;
  localparam logic [3:0] ADR_CTRL    = 4'd12;

  // control field; packed so that hsync_neg is bit 0
  typedef struct packed {
    logic screen_off;
    logic vsync_off;
    logic hsync_off;
    logic vsync_neg;
    logic hsync_neg;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  // pin level of a sync: forced inactive when off, then polarity applied
  function automatic logic sync_pin(input logic active, input logic off, input logic neg);
    logic gated;
    gated = active & ~off;
    return neg ? ~gated : gated;
  endfunction

endpackage

// File: rtl/crtc_char_clk.sv
module crtc_char_clk #(
  parameter int unsigned PIX_PER_CHAR = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic char_tick
);

  generate
    if (PIX_PER_CHAR > 1) begin : g_div
      localparam int unsigned PIX_W = $clog2(PIX_PER_CHAR);
      localparam logic [PIX_W-1:0] PIX_LAST = PIX_W'(PIX_PER_CHAR - 1);

      logic [PIX_W-1:0] pix_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                pix_q <= '0;
        else if (pix_q == PIX_LAST) pix_q <= '0;
        else                        pix_q <= pix_q + PIX_W'(1);
      end

      assign char_tick = (pix_q == PIX_LAST);

      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        char_tick |=> !char_tick) else $error("char tick too dense"); // R2
    end else begin : g_pass
      assign char_tick = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/crtc_axis.sv
module crtc_axis #(
  parameter int unsigned REG_W    = 9,
  parameter int unsigned BE_W     = 6,
  parameter int unsigned SE_W     = 5,
  parameter int unsigned WRAP_ADD = 4,
  localparam int unsigned CNT_W   = REG_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [REG_W-1:0] total,
  input  logic [REG_W-1:0] dend,
  input  logic [REG_W-1:0] bstart,
  input  logic [BE_W-1:0]  bend,
  input  logic [REG_W-1:0] sstart,
  input  logic [SE_W-1:0]  send,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic             disp,
  output logic             blank,
  output logic             sync
);

  // last count value before returning to zero
  function automatic logic [CNT_W-1:0] last_index(input logic [REG_W-1:0] t);
    return CNT_W'(t) + CNT_W'(WRAP_ADD);
  endfunction

  // first count value of the blank pulse
  function automatic logic [CNT_W-1:0] blank_first(input logic [REG_W-1:0] s);
    return CNT_W'(s) + CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] cnt_q, cnt_next;
  logic             at_term;
  logic             blank_q, sync_q;
  logic             blank_set, blank_clr, sync_set, sync_clr;

  assign at_term  = (cnt_q == last_index(total));
  assign wrap     = step & at_term;
  assign cnt_next = at_term ? '0 : cnt_q + CNT_W'(1);

  // blank ends after the matching count; sync ends on the matching count
  assign blank_set = (cnt_next == blank_first(bstart));
  assign blank_clr = (cnt_q[BE_W-1:0] == bend);
  assign sync_set  = (cnt_next == CNT_W'(sstart));
  assign sync_clr  = (cnt_next[SE_W-1:0] == send);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      blank_q <= 1'b0;
      sync_q  <= 1'b0;
    end else if (step) begin
      cnt_q <= cnt_next;
      if (blank_set)      blank_q <= 1'b1;
      else if (blank_clr) blank_q <= 1'b0;
      if (sync_set)       sync_q  <= 1'b1;
      else if (sync_clr)  sync_q  <= 1'b0;
    end
  end

  assign cnt   = cnt_q;
  assign disp  = (cnt_q <= CNT_W'(dend));
  assign blank = blank_q;
  assign sync  = sync_q;

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0)) else $error("counter missed wrap"); // R2
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !at_term) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))) else $error("counter missed step"); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt_q)) else $error("counter moved without step"); // R2
  AST_BLANK_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(blank_q) |-> $past(step)) else $error("blank moved off step"); // R5
  AST_SYNC_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sync_q) |-> $past(step)) else $error("sync moved off step"); // R6

endmodule

// File: rtl/crtc_regs.sv
module crtc_regs
  import crtc_pkg::*;
#(
  parameter int unsigned HREG_W = 9,
  parameter int unsigned VREG_W = 11,
  parameter int unsigned HBE_W  = 6,
  parameter int unsigned HSE_W  = 5,
  parameter int unsigned VBE_W  = 8,
  parameter int unsigned VSE_W  = 4,
  parameter int unsigned DATA_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              frame_end,
  output logic [HREG_W-1:0] h_total,
  output logic [HREG_W-1:0] h_dend,
  output logic [HREG_W-1:0] h_bstart,
  output logic [HBE_W-1:0]  h_bend,
  output logic [HREG_W-1:0] h_sstart,
  output logic [HSE_W-1:0]  h_send,
  output logic [VREG_W-1:0] v_total,
  output logic [VREG_W-1:0] v_dend,
  output logic [VREG_W-1:0] v_bstart,
  output logic [VBE_W-1:0]  v_bend,
  output logic [VREG_W-1:0] v_sstart,
  output logic [VSE_W-1:0]  v_send,
  output ctrl_t             ctrl
);

  typedef struct packed {
    logic [HREG_W-1:0] ht;
    logic [HREG_W-1:0] hde;
    logic [HREG_W-1:0] hbs;
    logic [HBE_W-1:0]  hbe;
    logic [HREG_W-1:0] hss;
    logic [HSE_W-1:0]  hse;
    logic [VREG_W-1:0] vt;
    logic [VREG_W-1:0] vde;
    logic [VREG_W-1:0] vbs;
    logic [VBE_W-1:0]  vbe;
    logic [VREG_W-1:0] vss;
    logic [VSE_W-1:0]  vse;
  } timing_t;

  timing_t shadow_q, work_q;
  ctrl_t   ctrl_q;

  // shadow bank: written any time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_HTOTAL:  shadow_q.ht  <= wr_data[HREG_W-1:0];
        ADR_HDEND:   shadow_q.hde <= wr_data[HREG_W-1:0];
        ADR_HBSTART: shadow_q.hbs <= wr_data[HREG_W-1:0];
        ADR_HBEND:   shadow_q.hbe <= wr_data[HBE_W-1:0];
        ADR_HSSTART: shadow_q.hss <= wr_data[HREG_W-1:0];
        ADR_HSEND:   shadow_q.hse <= wr_data[HSE_W-1:0];
        ADR_VTOTAL:  shadow_q.vt  <= wr_data[VREG_W-1:0];
        ADR_VDEND:   shadow_q.vde <= wr_data[VREG_W-1:0];
        ADR_VBSTART: shadow_q.vbs <= wr_data[VREG_W-1:0];
        ADR_VBEND:   shadow_q.vbe <= wr_data[VBE_W-1:0];
        ADR_VSSTART: shadow_q.vss <= wr_data[VREG_W-1:0];
        ADR_VSEND:   shadow_q.vse <= wr_data[VSE_W-1:0];
        default: ;
      endcase
    end
  end

  // working set: copied only when the frame wraps
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         work_q <= '0;
    else if (frame_end) work_q <= shadow_q;
  end

  // control acts at once
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             ctrl_q <= '0;
    else if (wr_en && wr_addr == ADR_CTRL)  ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
  end

  assign h_total  = work_q.ht;
  assign h_dend   = work_q.hde;
  assign h_bstart = work_q.hbs;
  assign h_bend   = work_q.hbe;
  assign h_sstart = work_q.hss;
  assign h_send   = work_q.hse;
  assign v_total  = work_q.vt;
  assign v_dend   = work_q.vde;
  assign v_bstart = work_q.vbs;
  assign v_bend   = work_q.vbe;
  assign v_sstart = work_q.vss;
  assign v_send   = work_q.vse;
  assign ctrl     = ctrl_q;

  AST_WORK_LOADS_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (work_q == $past(shadow_q))) else $error("working set not loaded"); // R12
  AST_WORK_FROZEN_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(work_q)) else $error("working set changed mid frame"); // R12
  AST_SHADOW_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(shadow_q)) else $error("shadow changed without write"); // R12

endmodule

// File: rtl/crtc_sync_out.sv
module crtc_sync_out
  import crtc_pkg::*;
(
  input  logic  h_sync_flag,
  input  logic  v_sync_flag,
  input  logic  h_disp,
  input  logic  v_disp,
  input  ctrl_t ctrl,
  output logic  hsync,
  output logic  vsync,
  output logic  disp_en
);

  assign hsync   = sync_pin(h_sync_flag, ctrl.hsync_off, ctrl.hsync_neg);
  assign vsync   = sync_pin(v_sync_flag, ctrl.vsync_off, ctrl.vsync_neg);
  assign disp_en = h_disp & v_disp & ~ctrl.screen_off;

endmodule

// File: rtl/crtc_timing.sv
module crtc_timing
  import crtc_pkg::*;
#(
  parameter int unsigned PIX_PER_CHAR = 8,
  parameter int unsigned HREG_W       = 9,
  parameter int unsigned VREG_W       = 11,
  parameter int unsigned HBE_W        = 6,
  parameter int unsigned HSE_W        = 5,
  parameter int unsigned VBE_W        = 8,
  parameter int unsigned VSE_W        = 4,
  parameter int unsigned H_WRAP_ADD   = 4,
  parameter int unsigned V_WRAP_ADD   = 1,
  localparam int unsigned DATA_W      = (VREG_W > HREG_W) ? VREG_W : HREG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hsync,
  output logic              vsync,
  output logic              hblank,
  output logic              vblank,
  output logic              disp_en,
  output logic [VREG_W-1:0] raster_line
);

  logic              char_tick;
  logic              h_wrap, v_wrap;
  logic [HREG_W-1:0] h_total, h_dend, h_bstart, h_sstart;
  logic [HBE_W-1:0]  h_bend;
  logic [HSE_W-1:0]  h_send;
  logic [VREG_W-1:0] v_total, v_dend, v_bstart, v_sstart;
  logic [VBE_W-1:0]  v_bend;
  logic [VSE_W-1:0]  v_send;
  ctrl_t             ctrl;
  logic [HREG_W:0]   h_cnt;
  logic [VREG_W:0]   v_cnt;
  logic              h_disp, v_disp, h_sync_flag, v_sync_flag;
  logic              unused_cnt_bits;

  crtc_char_clk #(.PIX_PER_CHAR(PIX_PER_CHAR)) u_char (
    .clk       (clk),
    .rst_n     (rst_n),
    .char_tick (char_tick)
  );

  crtc_regs #(
    .HREG_W(HREG_W), .VREG_W(VREG_W), .HBE_W(HBE_W), .HSE_W(HSE_W),
    .VBE_W(VBE_W), .VSE_W(VSE_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .frame_end (v_wrap),
    .h_total   (h_total),
    .h_dend    (h_dend),
    .h_bstart  (h_bstart),
    .h_bend    (h_bend),
    .h_sstart  (h_sstart),
    .h_send    (h_send),
    .v_total   (v_total),
    .v_dend    (v_dend),
    .v_bstart  (v_bstart),
    .v_bend    (v_bend),
    .v_sstart  (v_sstart),
    .v_send    (v_send),
    .ctrl      (ctrl)
  );

  crtc_axis #(.REG_W(HREG_W), .BE_W(HBE_W), .SE_W(HSE_W), .WRAP_ADD(H_WRAP_ADD)) u_haxis (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (char_tick),
    .total  (h_total),
    .dend   (h_dend),
    .bstart (h_bstart),
    .bend   (h_bend),
    .sstart (h_sstart),
    .send   (h_send),
    .cnt    (h_cnt),
    .wrap   (h_wrap),
    .disp   (h_disp),
    .blank  (hblank),
    .sync   (h_sync_flag)
  );

  crtc_axis #(.REG_W(VREG_W), .BE_W(VBE_W), .SE_W(VSE_W), .WRAP_ADD(V_WRAP_ADD)) u_vaxis (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (h_wrap),
    .total  (v_total),
    .dend   (v_dend),
    .bstart (v_bstart),
    .bend   (v_bend),
    .sstart (v_sstart),
    .send   (v_send),
    .cnt    (v_cnt),
    .wrap   (v_wrap),
    .disp   (v_disp),
    .blank  (vblank),
    .sync   (v_sync_flag)
  );

  crtc_sync_out u_out (
    .h_sync_flag (h_sync_flag),
    .v_sync_flag (v_sync_flag),
    .h_disp      (h_disp),
    .v_disp      (v_disp),
    .ctrl        (ctrl),
    .hsync       (hsync),
    .vsync       (vsync),
    .disp_en     (disp_en)
  );

  assign raster_line     = v_cnt[VREG_W-1:0];
  assign unused_cnt_bits = v_cnt[VREG_W] ^ (|h_cnt);

  AST_LINE_MOVES_AT_HWRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(raster_line) |-> $past(h_wrap)) else $error("line moved mid line"); // R3
  AST_HWRAP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    h_wrap |-> char_tick) else $error("line wrap off character tick"); // R2

endmodule

// File: tb/crtc_timing_test.sv
module crtc_timing_test;

  localparam int PIX = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [10:0] wr_data;
  logic        hsync, vsync, hblank, vblank, disp_en;
  logic [10:0] raster_line;

  int checks = 0;
  int failures = 0;
  bit comparing = 0;
  bit done = 0;

  always #5 clk = ~clk;

  crtc_timing uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hsync(hsync), .vsync(vsync), .hblank(hblank), .vblank(vblank),
    .disp_en(disp_en), .raster_line(raster_line)
  );

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, actual, expected, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int pend [13];
  int act  [13];
  int m_pix, m_ch, m_ln, m_hb, m_hs, m_vb, m_vs;
  int nch, nln;
  bit fend;

  function automatic int field_mod(input int a);
    case (a)
      0, 1, 2, 4:   return 512;
      3:            return 64;
      5:            return 32;
      6, 7, 8, 10:  return 2048;
      9:            return 256;
      11:           return 16;
      default:      return 32;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 13; i++) begin pend[i] = 0; act[i] = 0; end
      m_pix = 0; m_ch = 0; m_ln = 0; m_hb = 0; m_hs = 0; m_vb = 0; m_vs = 0;
    end else begin
      fend = 0;
      if (m_pix == PIX - 1) begin
        nch = (m_ch == act[0] + 4) ? 0 : m_ch + 1;
        if (nch == act[2] + 1)          m_hb = 1;
        else if (m_ch % 64 == act[3])   m_hb = 0;
        if (nch == act[4])              m_hs = 1;
        else if (nch % 32 == act[5])    m_hs = 0;
        if (nch == 0) begin
          nln = (m_ln == act[6] + 1) ? 0 : m_ln + 1;
          if (nln == act[8] + 1)          m_vb = 1;
          else if (m_ln % 256 == act[9])  m_vb = 0;
          if (nln == act[10])             m_vs = 1;
          else if (nln % 16 == act[11])   m_vs = 0;
          fend = (nln == 0);
          m_ln = nln;
        end
        m_ch = nch;
      end
      if (fend) for (int i = 0; i < 12; i++) act[i] = pend[i];
      if (wr_en && wr_addr <= 4'd12) begin
        pend[wr_addr] = int'(wr_data) % field_mod(int'(wr_addr));
        if (wr_addr == 4'd12) act[12] = pend[12];
      end
      m_pix = (m_pix + 1) % PIX;
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (comparing) begin
      int hact, vact, exp_de;
      hact = m_hs && !act[12][2];
      vact = m_vs && !act[12][3];
      exp_de = (m_ch <= act[1]) && (m_ln <= act[7]) && !act[12][4];
      check("R6 hsync", hsync, act[12][0] ? !hact : hact);
      check("R8 vsync", vsync, act[12][1] ? !vact : vact);
      check("R5 hblank", hblank, m_hb);
      check("R7 vblank", vblank, m_vb);
      check("R4 disp_en", disp_en, exp_de);
      check("R3 raster_line", raster_line, m_ln % 2048);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 11'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // returns at the first negedge of a new frame (line 0, character 0)
  task automatic wait_frame();
    int prev;
    prev = raster_line;
    forever begin
      @(negedge clk);
      if (prev != 0 && raster_line == 0) break;
      prev = raster_line;
    end
  endtask

  // cycles from one raster change to the next
  task automatic line_length(output int n);
    int start;
    start = raster_line;
    while (raster_line == start) @(negedge clk);
    start = raster_line;
    n = 0;
    while (raster_line == start) begin @(negedge clk); n++; end
  endtask

  task automatic program_cfg(input int hse, input int vbe, input int vse, input int hbe);
    wr(0, 7);  wr(1, 7);  wr(2, 7);  wr(3, hbe); wr(4, 9);  wr(5, hse);
    wr(6, 10); wr(7, 7);  wr(8, 7);  wr(9, vbe); wr(10, 9); wr(11, vse);
  endtask

  initial begin
    int n, maxl;
    bit seen_de, seen_hb;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 hsync", hsync, 0);
    check("R1 vsync", vsync, 0);
    check("R1 hblank", hblank, 0);
    check("R1 vblank", vblank, 0);
    check("R1 disp_en", disp_en, 1);
    check("R1 raster_line", raster_line, 0);
    rst_n = 1'b1;
    comparing = 1;
    // R2 default line: (0+5)*8
    line_length(n);
    check("R2 default line length", n, 40);

    // config A: 96-pixel lines, 12-line frames
    program_cfg(11, 11, 10, 11);
    wait_frame(); wait_frame();
    check("R4 disp_en at frame start", disp_en, 1);
    check("R5 hblank at frame start", hblank, 0);
    check("R7 vblank at frame start", vblank, 0);
    line_length(n);
    check("R2 line length", n, 96);
    wait_frame();
    maxl = 0;
    while (raster_line != 0 || maxl == 0) begin
      if (raster_line > maxl) maxl = raster_line;
      @(negedge clk);
    end
    check("R3 last line", maxl, 11);

    // R12 deferred timing write
    while (raster_line != 2) @(negedge clk);
    wr(0, 3);
    line_length(n);
    check("R12 line length before wrap", n, 96);
    wait_frame();
    line_length(n);
    check("R12 line length after wrap", n, 64);
    wr(0, 7);
    wait_frame(); wait_frame();

    // R9 negative polarity: line 0 is outside both pulses
    wr(12, 5'b00011);
    check("R12 control next clock", vsync, 1);
    wait_frame();
    check("R9 vsync idle high", vsync, 1);
    wait_frame();
    wr(12, 5'b00000);
    check("R9 vsync idle low", vsync, 0);

    // R10 disable bits
    wr(12, 5'b01100);
    seen_hb = 0;
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk);
      if (hsync || vsync) seen_hb = 1;
    end
    check("R10 syncs held inactive", seen_hb, 0);
    wr(12, 5'b01111);
    check("R10 inactive level with negative polarity", hsync & vsync, 1);

    // R11 screen off keeps timing running
    wr(12, 5'b10000);
    seen_de = 0; seen_hb = 0; maxl = 0;
    for (int i = 0; i < 1300; i++) begin
      @(negedge clk);
      if (disp_en) seen_de = 1;
      if (hblank) seen_hb = 1;
      if (raster_line > maxl) maxl = raster_line;
    end
    check("R11 disp_en held low", seen_de, 0);
    check("R11 blank still toggles", seen_hb, 1);
    check("R11 raster still runs", maxl, 11);
    wr(12, 0);

    // config B: end values below start, pulses wrap
    program_cfg(3, 5, 4, 2);
    wait_frame(); wait_frame(); wait_frame();
    check("R6 hsync wraps into line start", hsync, 1);
    check("R8 vsync wraps into frame start", vsync, 1);
    check("R7 vblank wraps into frame start", vblank, 1);
    check("R5 hblank wraps into line start", hblank, 1);
    wait_frame();
    repeat (40) @(negedge clk);
    check("R6 hsync cleared at char 3", hsync, 0);
    wait_frame();

    comparing = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      comparing = 0;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule